// File: doc/BRIEF.md
# Free-Running Successive-Approximation Sequencer

This block sequences a 12-bit successive-approximation conversion without any help from the host. A slow conversion clock, nominally 250 kHz, drives it. It presents a trial code to an external DAC and reads back a one-bit comparator decision, which arrives synchronously. It settles one bit for every two clock periods, beginning at the most significant bit. A single start cycle comes before the bit slots and a single end cycle comes after them, so every conversion takes exactly 26 clocks. The next conversion then begins immediately.

In the end cycle a one-clock pulse copies the finished word into a holding register. The host may read that register at any moment and always receives the most recent complete conversion. A valid flag shows that at least one conversion has finished since reset. A busy output is high for the whole frame except the end cycle.

Top module: `sar_seq`

## Requirements
- R1: A frame lasts 26 cycles. Cycle 0 is START and `start_pulse` is high in it. Cycles 1 to 24 are the twelve bit slots. Cycle 25 is END. The next frame's START follows END with no host action. The first cycle after reset release is a START cycle.
- R2: Every conversion starts from a zero trial word, so `dac_code` is 0 during the START cycle.
- R3: Bit slots run from bit 11 down to bit 0. Slot k occupies cycles 2k+1 and 2k+2. In the first cycle of a slot, `dac_code` shows the trial bit set to 1, the higher bits as already decided, and the lower bits at 0. In the first slot this gives `dac_code` = 0x800.
- R4: In the second cycle of a slot, `cmp_hi` is sampled. If it is 1, meaning the trial code is too high, the bit is cleared. Otherwise the bit is kept. When the comparator reports `dac_code > vin`, the finished word therefore equals `vin`.
- R5: `end_pulse` is high for exactly one cycle, cycle 25. Its clock edge loads the finished word into `result`, and the new value is visible from the next cycle.
- R6: `result` does not change between two END edges.
- R7: After reset, `result` is 0 and `result_valid` is 0. `result_valid` goes to 1 at the first END edge and stays at 1.
- R8: `busy` is high in cycles 0 to 24 and low in the END cycle.
- R9: During the END cycle, `dac_code` shows the finished word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cmp_hi | input | 1 | Comparator decision: 1 means the trial code is above the input |
| dac_code | output | 12 | Trial code presented to the DAC |
| start_pulse | output | 1 | High in the START cycle |
| end_pulse | output | 1 | High in the END cycle |
| busy | output | 1 | High from START through the last bit slot |
| result | output | 12 | Holding register containing the last complete word |
| result_valid | output | 1 | Set once the first conversion has finished |

## Verification
Two things happen on the same END clock edge: the finished trial word is loaded into the holding register, and the trial register is cleared for the next frame. The load must capture the old trial value, not the cleared one. Every frame exercises this. The bench models the comparator as `dac_code > vin` over all 4096 input codes, taken in a scattered order so that consecutive words differ widely. In the cycle after END it requires that `result` equals the previous `vin` and that `dac_code` has returned to zero.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Bit decided in frame cycle c (cycles 1..2W are bit slots).
  function automatic int slot_bit(int w, int c);
    return (w - 1) - ((c - 1) / 2);
  endfunction

  // First cycle of a bit slot: trial bit is forced high.
  function automatic logic slot_first(int c);
    return ((c - 1) % 2) == 0;
  endfunction

  function automatic int frame_len(int w);
    return 2 * w + 2;
  endfunction

endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int WIDTH = 12,
  parameter int BW    = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          start_o,
  output logic          end_o,
  output logic          set_o,
  output logic          decide_o,
  output logic [BW-1:0] bidx_o
);
  localparam int FRAME = sar_pkg::frame_len(WIDTH);
  localparam int CW    = $clog2(FRAME);

  logic [CW-1:0] cnt_q;
  logic          in_slot;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (cnt_q == CW'(FRAME - 1))  cnt_q <= '0;
    else                               cnt_q <= cnt_q + CW'(1);
  end

  assign start_o  = (cnt_q == '0);
  assign end_o    = (cnt_q == CW'(FRAME - 1));
  assign in_slot  = !start_o && !end_o;
  assign set_o    = in_slot && sar_pkg::slot_first(int'(cnt_q));
  assign decide_o = in_slot && !sar_pkg::slot_first(int'(cnt_q));
  assign bidx_o   = in_slot ? BW'(sar_pkg::slot_bit(WIDTH, int'(cnt_q))) : '0;

  // R1
  end_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> start_o);

  // R3
  set_then_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> (decide_o && bidx_o == $past(bidx_o)));

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int WIDTH = 12,
  parameter int BW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             set_i,
  input  logic             decide_i,
  input  logic [BW-1:0]    bidx_i,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] dac_o
);
  logic [WIDTH-1:0] trial_q;
  logic [WIDTH-1:0] probe;

  assign probe = WIDTH'(1) << bidx_i;

  always_ff @(posedge clk) begin
    if (!rst_n)        trial_q <= '0;
    else if (end_i)    trial_q <= '0;
    else if (set_i)    trial_q <= trial_q | probe;
    else if (decide_i) trial_q[bidx_i] <= ~cmp_hi_i;
  end

  assign trial_o = trial_q;
  assign dac_o   = set_i ? (trial_q | probe) : trial_q;

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (dac_o == '0));

  // R4
  decide_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_i |=> (trial_q[$past(bidx_i)] == !$past(cmp_hi_i)));

endmodule

// File: rtl/sar_hold.sv
module sar_hold #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] result_o,
  output logic             valid_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else if (load_i) begin
      result_o <= word_i;
      valid_o  <= 1'b1;
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(result_o));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic             start_pulse,
  output logic             end_pulse,
  output logic             busy,
  output logic [WIDTH-1:0] result,
  output logic             result_valid
);
  localparam int BW = $clog2(WIDTH);

  logic          set_w, decide_w;
  logic [BW-1:0] bidx_w;
  logic [WIDTH-1:0] trial_w;

  sar_timer #(.WIDTH(WIDTH), .BW(BW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_o(start_pulse), .end_o(end_pulse),
    .set_o(set_w), .decide_o(decide_w), .bidx_o(bidx_w)
  );

  sar_trial #(.WIDTH(WIDTH), .BW(BW)) u_trial (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_pulse), .end_i(end_pulse),
    .set_i(set_w), .decide_i(decide_w), .bidx_i(bidx_w),
    .cmp_hi_i(cmp_hi), .trial_o(trial_w), .dac_o(dac_code)
  );

  sar_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_i(end_pulse), .word_i(trial_w),
    .result_o(result), .valid_o(result_valid)
  );

  assign busy = !end_pulse;

  // R5
  end_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> (result == $past(dac_code) && result_valid));

endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] vin = '0;
  logic cmp_hi;
  logic [W-1:0] dac_code, result;
  logic start_pulse, end_pulse, busy, result_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // comparator model: trial above input
  assign cmp_hi = (dac_code > vin);

  sar_seq #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .start_pulse(start_pulse), .end_pulse(end_pulse), .busy(busy),
    .result(result), .result_valid(result_valid)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    chk("R7 reset result", int'(result), 0);
    chk("R7 reset valid", int'(result_valid), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 first cycle is start", int'(start_pulse), 1);
    prev = 0;
    for (int i = 0; i < 4096; i++) begin
      int v;
      v = (i * 1031) % 4096;
      // START cycle
      chk("R1 start", int'(start_pulse), 1);
      chk("R2 dac zero at start", int'(dac_code), 0);
      chk("R8 busy at start", int'(busy), 1);
      chk("R7 valid", int'(result_valid), (i == 0) ? 0 : 1);
      chk("R5 result after end", int'(result), prev);
      vin = W'(v);
      @(negedge clk);
      chk("R3 first probe", int'(dac_code), 2048);
      for (int n = 2; n <= 25; n++) begin
        @(negedge clk);
        if (n == 3) chk("R3 second probe", int'(dac_code), ((v >= 2048) ? 2048 : 0) + 1024);
        if (n < 25) begin
          if (n % 6 == 0) begin
            chk("R6 result held", int'(result), prev);
            chk("R8 busy in slot", int'(busy), 1);
            chk("R1 no end in slot", int'(end_pulse), 0);
          end
        end else begin
          chk("R1 end pulse", int'(end_pulse), 1);
          chk("R8 busy low at end", int'(busy), 0);
          chk("R4 R9 final word", int'(dac_code), v);
          chk("R6 result before load", int'(result), prev);
        end
      end
      @(negedge clk);
      prev = v;
    end
    chk("R5 last result", int'(result), prev);
    chk("R1 end single cycle", int'(end_pulse), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule